// File: doc/BRIEF.md
# Timed Discharge Measurement Sequencer

This block is the digital controller of a delay-based temperature sensor. Once per measurement period it switches on the sensing path and holds a sensing node in precharge for a fixed number of cycles. It then releases the node and counts system clock cycles until a threshold-crossed input reports that the node has discharged. The discharge current depends strongly on temperature, so the elapsed count is the temperature code. The count is a 6-bit value that saturates at 63. It is latched to the output together with a one-cycle valid pulse.

Between measurements every control to the sensing path is low, so the analog cell draws no power. Measurements are paced by a timebase tick supplied from outside, roughly one per second. The first measurement after reset starts by itself, without waiting for a tick. The threshold input is asynchronous to the system clock. It passes through a two-stage synchroniser before it can stop the counter, and this adds a fixed two-cycle offset to every code.

Top module: `tdm_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, `prechg_o`, `dischg_en_o`, `sens_pwr_o` and `code_vld_o` are 0 and `code_o` is 0.
- R2: After reset is released, a measurement starts with no tick: `prechg_o` and `sens_pwr_o` rise at the first clock edge with reset low.
- R3: `prechg_o` stays high for exactly PRE_CYCLES cycles (default 8). `dischg_en_o` rises in the cycle it falls. The two are never high together, and `sens_pwr_o` is high whenever either of them is.
- R4: Let n be the cycle in which `thr_crossed` is first high, counting the first cycle with `dischg_en_o` high as n = 0. The code is min(n + 2, 63). If `thr_crossed` is already high throughout the discharge phase, the code is 0.
- R5: If `thr_crossed` never rises, the count stops at 63 without wrapping, and the measurement ends with code 63 after 64 cycles of discharge.
- R6: `code_vld_o` is a one-cycle pulse. `code_o` takes the new code in the same cycle and holds its previous value at all other times.
- R7: `dischg_en_o` stays high for code + 1 cycles. In the cycle after it falls, `code_vld_o` is high and `sens_pwr_o` goes low.
- R8: Between measurements all three controls stay low. A new measurement starts only when `period_tick` is high while the block is idle. A tick that arrives during a measurement is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_tick | input | 1 | One-cycle measurement period strobe |
| thr_crossed | input | 1 | Asynchronous flag from the sensing node: threshold crossed |
| prechg_o | output | 1 | Precharge the sensing node |
| dischg_en_o | output | 1 | Release the discharge path |
| sens_pwr_o | output | 1 | Power enable of the sensing path |
| code_o | output | 6 | Latched temperature code |
| code_vld_o | output | 1 | One-cycle pulse when code_o is updated |

## Verification
The bench targets the very short discharge: a crossing already present at release must give code 0, and a crossing in the first discharge cycle must give code 2. A design that leaves out the synchroniser offset or counts one edge too many would be off by one or two. It drives crossings just under and just over the saturation point, and also a crossing that never comes. A counter that wraps would report a small code here, and a sequencer with no timeout would never end the measurement. It also sends a tick in the middle of a measurement, where a design that queued or honoured the tick would start an unrequested extra measurement. Around these cases it runs random crossing delays and checks the precharge length, the overlap of the controls and the hold of the previous code.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PRECHG = 2'd1,
    ST_DISCHG = 2'd2,
    ST_LATCH  = 2'd3
  } tdm_state_e;

  typedef struct packed {
    logic pwr;
    logic pre;
    logic dis;
  } tdm_ctl_t;

  // Control levels the sensing path sees in each phase.
  function automatic tdm_ctl_t ctl_for(tdm_state_e s);
    tdm_ctl_t c;
    c = '0;
    unique case (s)
      ST_PRECHG: begin c.pwr = 1'b1; c.pre = 1'b1; end
      ST_DISCHG: begin c.pwr = 1'b1; c.dis = 1'b1; end
      ST_LATCH:  c.pwr = 1'b1;
      default:   c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/tdm_satcnt.sv
module tdm_satcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);
  assign full = &cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (inc && !full) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
#(
  parameter int PRE_CYCLES = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     crossed,
  input  logic     cnt_full,
  output tdm_ctl_t ctl,
  output logic     cnt_clr,
  output logic     cnt_inc,
  output logic     capture
);
  localparam int PRE_N = (PRE_CYCLES < 1) ? 1 : PRE_CYCLES;
  localparam int PRE_W = (PRE_N > 1) ? $clog2(PRE_N) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_N - 1);

  tdm_state_e       state, nxt;
  logic [PRE_W-1:0] pre_cnt;
  logic             pend;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (pend || tick)          nxt = ST_PRECHG;
      ST_PRECHG: if (pre_cnt == PRE_LAST)   nxt = ST_DISCHG;
      ST_DISCHG: if (crossed || cnt_full)   nxt = ST_LATCH;
      default:                              nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= 1'b1;
      pre_cnt <= '0;
      ctl     <= '0;
    end else begin
      state <= nxt;
      ctl   <= ctl_for(nxt);
      if (state != ST_IDLE) pend <= 1'b0;
      if (state == ST_PRECHG) pre_cnt <= pre_cnt + 1'b1;
      else                    pre_cnt <= '0;
    end
  end

  assign cnt_clr = (state == ST_IDLE);
  assign cnt_inc = (state == ST_DISCHG) && !crossed;
  assign capture = (state == ST_LATCH);
endmodule

// File: rtl/tdm_sequencer.sv
module tdm_sequencer
  import tdm_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int PRE_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_tick,
  input  logic              thr_crossed,
  output logic              prechg_o,
  output logic              dischg_en_o,
  output logic              sens_pwr_o,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o
);
  tdm_ctl_t          ctl;
  logic              crossed_s;
  logic              cnt_clr, cnt_inc, cnt_full, capture;
  logic [CODE_W-1:0] cnt;

  tdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(thr_crossed), .q(crossed_s)
  );

  tdm_satcnt #(.W(CODE_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .full(cnt_full)
  );

  tdm_ctrl #(.PRE_CYCLES(PRE_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .tick(period_tick), .crossed(crossed_s),
    .cnt_full(cnt_full), .ctl(ctl), .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc), .capture(capture)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o     <= '0;
      code_vld_o <= 1'b0;
    end else begin
      code_vld_o <= capture;
      if (capture) code_o <= cnt;
    end
  end

  assign prechg_o    = ctl.pre;
  assign dischg_en_o = ctl.dis;
  assign sens_pwr_o  = ctl.pwr;
endmodule

// File: rtl/tdm_sequencer_chk.sv
module tdm_sequencer_chk #(
  parameter int CODE_W     = 6,
  parameter int PRE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              prechg_o,
  input logic              dischg_en_o,
  input logic              sens_pwr_o,
  input logic [CODE_W-1:0] code_o,
  input logic              code_vld_o
);
  logic [31:0] pre_run;

  always_ff @(posedge clk) begin
    if (rst)           pre_run <= '0;
    else if (prechg_o) pre_run <= pre_run + 1;
    else               pre_run <= '0;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!prechg_o && !dischg_en_o && !sens_pwr_o && !code_vld_o && code_o == '0));

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(prechg_o && dischg_en_o));

  // R3
  pwr_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (prechg_o || dischg_en_o) |-> sens_pwr_o);

  // R3
  pre_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(prechg_o) |-> (pre_run == PRE_CYCLES && dischg_en_o));

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |=> !code_vld_o);

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !code_vld_o |-> $stable(code_o));

  // R7
  vld_after_dis_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |-> (!sens_pwr_o && $past(sens_pwr_o) && !$past(dischg_en_o)));

  // R8
  start_from_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prechg_o) |-> !$past(sens_pwr_o));
endmodule

bind tdm_sequencer tdm_sequencer_chk #(.CODE_W(CODE_W), .PRE_CYCLES(PRE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .prechg_o(prechg_o), .dischg_en_o(dischg_en_o),
  .sens_pwr_o(sens_pwr_o), .code_o(code_o), .code_vld_o(code_vld_o)
);

// File: tb/sim_tdm_sequencer.sv
`timescale 1ns/1ps
module sim_tdm_sequencer;
  localparam int PRE = 8;
  localparam int MAXC = 63;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       period_tick = 1'b0;
  logic       thr_crossed = 1'b0;
  logic       prechg_o, dischg_en_o, sens_pwr_o, code_vld_o;
  logic [5:0] code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tdm_sequencer #(.CODE_W(6), .PRE_CYCLES(PRE), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .period_tick(period_tick), .thr_crossed(thr_crossed),
    .prechg_o(prechg_o), .dischg_en_o(dischg_en_o), .sens_pwr_o(sens_pwr_o),
    .code_o(code_o), .code_vld_o(code_vld_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // d < 0: crossing never arrives; early: crossing high before release
  function automatic int exp_code(input int d, input bit early);
    if (early) return 0;
    if (d < 0 || d + 2 > MAXC) return MAXC;
    return d + 2;
  endfunction

  task automatic measure(input bit use_tick, input int d, input bit early, input bit tick_mid);
    int k;
    int pre_n;
    int e;
    bit held;
    logic [5:0] old;
    e = exp_code(d, early);
    old = code_o;
    held = 1'b1;
    if (use_tick) begin
      period_tick = 1'b1;
      @(negedge clk);
      period_tick = 1'b0;
    end
    chk(prechg_o && sens_pwr_o, use_tick ? "R8 start on tick" : "R2 auto start", prechg_o, 1);
    if (early) thr_crossed = 1'b1;
    pre_n = 0;
    while (prechg_o && pre_n < 1000) begin
      if (dischg_en_o) held = 1'b0;
      if (code_o != old) held = 1'b0;
      @(negedge clk);
      pre_n++;
    end
    chk(pre_n == PRE, "R3 precharge length", pre_n, PRE);
    chk(dischg_en_o && sens_pwr_o, "R3 discharge follows precharge", dischg_en_o, 1);
    k = 0;
    while (dischg_en_o && k < 200) begin
      if (k == d) thr_crossed = 1'b1;
      if (tick_mid) period_tick = (k == 1);
      if (code_o != old || code_vld_o) held = 1'b0;
      @(negedge clk);
      k++;
    end
    period_tick = 1'b0;
    chk(k == e + 1, "R7 discharge length", k, e + 1);
    chk(!code_vld_o && sens_pwr_o && code_o == old && held, "R6 previous code held", code_o, old);
    @(negedge clk);
    chk(code_vld_o == 1'b1, "R6 valid pulse", code_vld_o, 1);
    chk(!sens_pwr_o, "R7 power off after latch", sens_pwr_o, 0);
    if (d < 0 || d + 2 > MAXC)
      chk(code_o == e, "R5 saturated code", code_o, e);
    else
      chk(code_o == e, "R4 measured code", code_o, e);
    @(negedge clk);
    chk(!code_vld_o && code_o == e, "R6 pulse ends and code holds", code_vld_o, 0);
    thr_crossed = 1'b0;
    held = 1'b1;
    repeat (20) begin
      if (prechg_o || dischg_en_o || sens_pwr_o) held = 1'b0;
      @(negedge clk);
    end
    chk(held, tick_mid ? "R8 mid-measurement tick ignored" : "R8 idle controls low", held, 1);
  endtask

  initial begin
    int seed;
    int d;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk(!prechg_o && !dischg_en_o && !sens_pwr_o && !code_vld_o && code_o == 0,
        "R1 reset state", code_o, 0);
    rst = 1'b0;
    @(negedge clk);
    measure(1'b0, 10, 1'b0, 1'b0);   // R2 first run, R4 code 12
    measure(1'b1, 0, 1'b0, 1'b0);    // R4 earliest crossing -> 2
    measure(1'b1, 0, 1'b1, 1'b0);    // R4 crossing before release -> 0
    measure(1'b1, -1, 1'b0, 1'b0);   // R5 no crossing -> 63
    measure(1'b1, 60, 1'b0, 1'b0);   // R4 62
    measure(1'b1, 61, 1'b0, 1'b0);   // R5 boundary 63
    measure(1'b1, 20, 1'b0, 1'b1);   // R8 tick during measurement
    for (int i = 0; i < 12; i++) begin
      d = $urandom_range(0, 70);
      if (d > 66) d = -1;
      measure(1'b1, d, 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule